// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs clause-22 management transactions toward an Ethernet PHY over a two-wire management bus: a clock (MDC) and a bidirectional data line (MDIO). Software works through four 32-bit registers. Writing a complete frame word into the frame register starts a transfer. The block then sends 32 ones as a preamble, followed by the frame word, most significant bit first. MDC comes from the system clock through a programmable divider.

For a read frame, the block stops driving the data line at the second turnaround bit. It captures the 16 data bits that the PHY returns and stores them in the low half of the frame register. The top 16 bits of the frame register are left as they were. When the transfer ends, a sticky completion bit is set, and software clears it by writing a one to it. A self-clearing soft-reset bit stops any transfer in flight and returns every register to zero.

Top module: `mdio_master`

## Requirements
- R1: After the preamble, the block sends the 32 bits of the frame word, bit 31 first. The word is laid out as follows: bits 31:30 hold start code 01, bits 29:28 hold the opcode (10 = read, 01 = write), bits 27:23 hold the PHY address, bits 22:18 hold the register address, bits 17:16 hold turnaround 10, and bits 15:0 hold the data.
- R2: Each frame is preceded by 32 MDC cycles in which MDIO is driven to 1.
- R3: MDC has a period of 2×N system clocks, where N is the nonzero speed field. MDIO changes only after a falling MDC edge and is stable at each rising edge. MDC stays low whenever no transfer is in progress.
- R4: In a read frame (opcode 10), the output enable is low from frame bit 16 through bit 0, which are serial positions 47 to 63 counted from the first preamble bit. In every other position the line is driven. A write frame drives all 64 positions.
- R5: When a read ends, frame register bits 15:0 hold the 16 bits sampled on MDIO in data positions 48 to 63, first bit in bit 15. Bits 31:16 keep the word that was written. After a write, the register still holds the written word.
- R6: Bit 0 of the event register (address 1) is set when a transfer ends and stays set until it is cleared. Exactly 64 rising MDC edges occur per transfer.
- R7: Writing a 1 to event bit 0 clears it, and writing all ones also clears it. Writing 0 leaves it unchanged.
- R8: When the speed field is 0, a frame write is stored but starts nothing. MDC stays low and no event is raised.
- R9: A frame-register write during a transfer is ignored. The register keeps its contents, and the serial bits come from the original word.
- R10: Writing 1 to control bit 0 (address 3) stops any transfer and clears the frame, event and speed registers. The bit reads 1 for RST_CYCLES cycles and then reads 0.
- R11: The register map is: address 0 frame, 1 event (bit 0), 2 speed (field in bits 6:1, other bits read 0), 3 control (bit 0). After reset, every register reads 0, MDC is low and MDIO is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register word index |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | Resolved MDIO line value |

## Verification
The hardest part to check is the read turnaround. The bench PHY model counts rising MDC edges and starts driving the line only after a falling edge. This lets it confirm that the master releases the line at position 47 and captures the returned bits in the right order. The two mid-transfer disturbances, a second frame write and a soft reset, each need a transfer already under way. The bench starts a transfer and injects the disturbance after a fixed number of cycles. It then compares the serial record and the register read-back against the values the original word predicts.

// File: rtl/mdio_pkg.sv
// Shared constants and register indices for the management frame master.
// Assumes a clause-22 frame of 32 bits preceded by a fixed-length preamble.
package mdio_pkg;
    localparam int FRAME_W  = 32;
    localparam int PRE_LEN  = 32;
    localparam int TOTAL    = PRE_LEN + FRAME_W;
    localparam int IDX_W    = $clog2(TOTAL);
    localparam int FSEL_W   = $clog2(FRAME_W);
    localparam int DATA_W   = 16;
    // serial position where a read releases the line (second turnaround bit)
    localparam int REL_POS  = PRE_LEN + (FRAME_W - 1 - DATA_W);
    // first serial position carrying returned data
    localparam int DAT_POS  = PRE_LEN + (FRAME_W - DATA_W);
    localparam int OP_HI    = 29;
    localparam int OP_LO    = 28;
    localparam logic [1:0] OP_READ = 2'b10;
    localparam int SPD_LSB  = 1;

    typedef enum logic [1:0] {
        RA_FRAME = 2'd0,
        RA_EVENT = 2'd1,
        RA_SPEED = 2'd2,
        RA_CTRL  = 2'd3
    } reg_idx_e;
endpackage

// File: rtl/mdio_clkdiv.sv
// MDC generator. Latches the divisor at transfer start and toggles MDC
// every DIV system clocks while run is high. Assumes the divisor is nonzero
// whenever start is asserted. Gives one-cycle strobes ahead of each edge.
module mdio_clkdiv #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] div,
    input  logic             run,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    // Hold the divisor steady for the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (start)
            div_q <= div;
    end

    assign wrap = run && (cnt == div_q - 1'b1);
    assign rise = wrap && !mdc;
    assign fall = wrap && mdc;

    // Count half periods and toggle MDC; park low when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < div_q)); // R3
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall)); // R3
endmodule

// File: rtl/mdio_shifter.sv
// Serial engine. Sends the preamble and then the frame word MSB first,
// advancing one position per falling MDC edge. In read frames it releases
// the line from the second turnaround bit and shifts in data at rising edges.
// Assumes rise and fall strobes are mutually exclusive.
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [FRAME_W-1:0]  frame_in,
    input  logic                abort,
    input  logic                rise,
    input  logic                fall,
    input  logic                mdio_i,
    output logic                busy,
    output logic                done,
    output logic                is_read,
    output logic [DATA_W-1:0]   rd_data,
    output logic                mdio_o,
    output logic                mdio_oe
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);
    localparam logic [IDX_W-1:0] PRE_IDX  = IDX_W'(PRE_LEN);
    localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(REL_POS);
    localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DAT_POS);

    logic [IDX_W-1:0]   idx;
    logic [FRAME_W-1:0] word_q;
    logic [IDX_W-1:0]   off;
    logic [FSEL_W-1:0]  sel;
    logic               in_frame;

    // Sequence the transfer: load, advance on falls, capture on rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            idx     <= '0;
            word_q  <= '0;
            is_read <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                busy <= 1'b0;
            end else if (start) begin
                busy    <= 1'b1;
                idx     <= '0;
                word_q  <= frame_in;
                is_read <= (frame_in[OP_HI:OP_LO] == OP_READ);
                rd_data <= '0;
            end else if (busy) begin
                if (rise && is_read && (idx >= DAT_IDX))
                    rd_data <= {rd_data[DATA_W-2:0], mdio_i};
                if (fall) begin
                    if (idx == LAST_IDX) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            end
        end
    end

    // Choose the bit on the line for the current serial position.
    always_comb begin
        in_frame = (idx >= PRE_IDX);
        off      = idx - PRE_IDX;
        sel      = FSEL_W'(FRAME_W - 1) - off[FSEL_W-1:0];
        mdio_o   = busy ? (in_frame ? word_q[sel] : 1'b1) : 1'b0;
        mdio_oe  = busy && !(is_read && (idx >= REL_IDX));
    end

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R9
    AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !abort && is_read && fall && (idx == REL_IDX - 1'b1)) |=> !mdio_oe); // R4
endmodule

// File: rtl/mdio_regs.sv
// Register bank: frame word, sticky event, speed field and self-clearing
// soft reset. Decides when a transfer may start. Assumes done is a single
// cycle pulse that arrives after busy has dropped.
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int SPD_W      = 6,
    parameter int RST_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         addr,
    input  logic               wr,
    input  logic [FRAME_W-1:0] wdata,
    output logic [FRAME_W-1:0] rdata,
    input  logic               busy_i,
    input  logic               done_i,
    input  logic               is_read_i,
    input  logic [DATA_W-1:0]  rd_data_i,
    output logic [FRAME_W-1:0] frame_q,
    output logic [SPD_W-1:0]   div_q,
    output logic               start,
    output logic               srst_act
);
    localparam int RC_W = $clog2(RST_CYCLES + 1);
    localparam logic [RC_W-1:0] RC_LOAD = RC_W'(RST_CYCLES);

    logic            event_q;
    logic [RC_W-1:0] rst_cnt;
    logic            wr_frame;
    logic            accept;

    assign wr_frame = wr && (addr == RA_FRAME);
    assign srst_act = (rst_cnt != '0);
    assign accept   = wr_frame && !busy_i && !done_i && !srst_act;
    assign start    = accept && (div_q != '0);

    // Soft reset countdown.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_cnt <= '0;
        else if (!srst_act && wr && (addr == RA_CTRL) && wdata[0])
            rst_cnt <= RC_LOAD;
        else if (srst_act)
            rst_cnt <= rst_cnt - 1'b1;
    end

    // Frame word: software load when idle, read data on completion.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_act)
            frame_q <= '0;
        else if (done_i && is_read_i)
            frame_q[DATA_W-1:0] <= rd_data_i;
        else if (accept)
            frame_q <= wdata;
    end

    // Speed field load.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_act)
            div_q <= '0;
        else if (wr && (addr == RA_SPEED))
            div_q <= wdata[SPD_LSB +: SPD_W];
    end

    // Sticky completion flag, write-1-to-clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_act)
            event_q <= 1'b0;
        else if (done_i)
            event_q <= 1'b1;
        else if (wr && (addr == RA_EVENT) && wdata[0])
            event_q <= 1'b0;
    end

    // Read-back mux.
    always_comb begin
        rdata = '0;
        unique case (addr)
            RA_FRAME: rdata = frame_q;
            RA_EVENT: rdata[0] = event_q;
            RA_SPEED: rdata[SPD_LSB +: SPD_W] = div_q;
            RA_CTRL:  rdata[0] = srst_act;
            default:  rdata = '0;
        endcase
    end

    AST_DONE_SETS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !srst_act) |=> event_q); // R6
    AST_BUSY_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !done_i && !srst_act) |=> $stable(frame_q)); // R9
endmodule

// File: rtl/mdio_master.sv
// Top of the management frame master. Connects the register bank, the
// MDC divider and the serial engine. Assumes an external pull-up resolves
// MDIO while mdio_oe is low and mdio_i reflects the resolved line.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int SPD_W      = 6,
    parameter int RST_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [FRAME_W-1:0] frame_q;
    logic [SPD_W-1:0]   div_q;
    logic               start;
    logic               srst_act;
    logic               busy;
    logic               done;
    logic               is_read;
    logic [DATA_W-1:0]  rd_data;
    logic               rise;
    logic               fall;
    logic               run;

    assign run = busy && !srst_act;

    mdio_regs #(.SPD_W(SPD_W), .RST_CYCLES(RST_CYCLES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (reg_addr),
        .wr        (reg_wr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .busy_i    (busy),
        .done_i    (done),
        .is_read_i (is_read),
        .rd_data_i (rd_data),
        .frame_q   (frame_q),
        .div_q     (div_q),
        .start     (start),
        .srst_act  (srst_act)
    );

    mdio_clkdiv #(.DIV_W(SPD_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .div   (div_q),
        .run   (run),
        .mdc   (mdc),
        .rise  (rise),
        .fall  (fall)
    );

    mdio_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .frame_in (reg_wdata),
        .abort    (srst_act),
        .rise     (rise),
        .fall     (fall),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .done     (done),
        .is_read  (is_read),
        .rd_data  (rd_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc); // R3
    AST_MDIO_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $stable(mdio_o)); // R3
    AST_PREAMBLE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mdio_oe && mdio_o)); // R2
    AST_DIV0_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_FRAME && div_q == '0 && !busy) |=> !busy); // R8
    AST_SRST_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(srst_act) |-> !busy); // R10
endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
    localparam int RSTC = 4;
    localparam int WD   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int checks = 0;
    int errors = 0;

    // PHY model state (driven only by the monitor block)
    int   cyc = 0;
    int   rise_total = 0;
    int   last_rise = 0;
    logic mdc_prev = 1'b0;
    logic phy_bit = 1'b1;
    logic line_bits [64];
    logic oe_bits [64];
    int   per [64];
    // driven only by the main flow
    int          mon_base = 0;
    logic [15:0] phy_resp = 16'h0;

    always #4 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : phy_bit;

    mdio_master #(.SPD_W(6), .RST_CYCLES(RSTC)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // Bus monitor and PHY responder, sampled away from the active edge.
    always @(negedge clk) begin
        int k;
        cyc = cyc + 1;
        if (mdc && !mdc_prev) begin
            k = rise_total - mon_base;
            if (k >= 0 && k < 64) begin
                line_bits[k] = mdio_i;
                oe_bits[k]   = mdio_oe;
                per[k]       = cyc - last_rise;
            end
            last_rise  = cyc;
            rise_total = rise_total + 1;
        end
        if (!mdc && mdc_prev) begin
            k = rise_total - mon_base;
            if (k >= 48 && k <= 63) phy_bit = phy_resp[63-k];
            else if (k == 47)       phy_bit = 1'b0;
            else                    phy_bit = 1'b1;
        end
        mdc_prev = mdc;
    end

    // Watchdog
    always @(negedge clk) begin
        if (cyc == WD) begin
            $display("FAIL R6 watchdog expired actual=%0d expected<%0d", cyc, WD);
            $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_now(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] mk(input bit rdop, input logic [4:0] p,
                                       input logic [4:0] r, input logic [15:0] d);
        return {2'b01, (rdop ? 2'b10 : 2'b01), p, r, 2'b10, d};
    endfunction

    task automatic wait_event(input int limit, output bit seen);
        logic [31:0] v;
        seen = 1'b0;
        for (int i = 0; i < limit && !seen; i++) begin
            @(negedge clk);
            rd_now(2'd1, v);
            seen = v[0];
        end
    endtask

    task automatic run_txn(input int d, input logic [31:0] word,
                           input logic [15:0] resp, input bit inject);
        logic [31:0] v;
        bit seen, ok;
        bit rdop;
        int nb;
        rdop = (word[29:28] == 2'b10);
        wr(2'd2, 32'(d) << 1);
        mon_base = rise_total;
        phy_resp = resp;
        wr(2'd0, word);
        if (inject) begin
            repeat (20) @(negedge clk);
            wr(2'd0, ~word);
            rd_now(2'd0, v);
            chk(v == word, "R9", "frame changed by busy write", v, word);
        end
        wait_event(64 * 2 * d + 40, seen);
        chk(seen, "R6", "event after transfer", {31'd0, seen}, 32'd1);
        chk(rise_total - mon_base == 64, "R6", "rising MDC count",
            32'(rise_total - mon_base), 32'd64);
        // R2 preamble
        ok = 1'b1;
        for (int k = 0; k < 32; k++) if (line_bits[k] !== 1'b1 || oe_bits[k] !== 1'b1) ok = 1'b0;
        chk(ok, "R2", "preamble ones driven", {31'd0, ok}, 32'd1);
        // R1 frame bits
        nb = rdop ? 14 : 32;
        ok = 1'b1;
        for (int i = 0; i < nb; i++) if (line_bits[32+i] !== word[31-i]) ok = 1'b0;
        chk(ok, "R1", "serial frame bits", word, word);
        // R4 drive pattern
        ok = 1'b1;
        for (int k = 0; k < 64; k++)
            if (oe_bits[k] !== ((rdop && k >= 47) ? 1'b0 : 1'b1)) ok = 1'b0;
        chk(ok, "R4", "output enable pattern", {31'd0, ok}, 32'd1);
        // R3 MDC period
        ok = 1'b1;
        for (int k = 1; k < 64; k++) if (per[k] != 2 * d) ok = 1'b0;
        chk(ok, "R3", "MDC period", 32'(per[1]), 32'(2 * d));
        chk(mdc == 1'b0, "R3", "MDC low after transfer", {31'd0, mdc}, 32'd0);
        // R5 read-back
        rd_now(2'd0, v);
        if (rdop)
            chk(v == {word[31:16], resp}, "R5", "read data in frame", v, {word[31:16], resp});
        else
            chk(v == word, "R5", "write frame kept", v, word);
        // R7 clear
        wr(2'd1, 32'd1);
        rd_now(2'd1, v);
        chk(v == 32'd0, "R7", "event cleared by one", v, 32'd0);
    endtask

    initial begin
        logic [31:0] v;
        int n;
        bit seen;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state and map
        for (int a = 0; a < 4; a++) begin
            rd_now(2'(a), v);
            chk(v == 32'd0, "R11", "register reset value", v, 32'd0);
        end
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R11", "idle pins", {30'd0, mdc, mdio_oe}, 32'd0);
        wr(2'd2, 32'hFFFF_FFFF);
        rd_now(2'd2, v);
        chk(v == 32'h0000_007E, "R11", "speed field mask", v, 32'h7E);

        // R8 divisor zero
        wr(2'd2, 32'd0);
        n = rise_total;
        wr(2'd0, mk(1'b0, 5'd3, 5'd4, 16'hBEEF));
        repeat (200) @(negedge clk);
        chk(rise_total == n, "R8", "no MDC with zero field", 32'(rise_total - n), 32'd0);
        rd_now(2'd1, v);
        chk(v == 32'd0, "R8", "no event with zero field", v, 32'd0);
        rd_now(2'd0, v);
        chk(v == mk(1'b0, 5'd3, 5'd4, 16'hBEEF), "R8", "frame stored", v, mk(1'b0, 5'd3, 5'd4, 16'hBEEF));

        // R1/R4 write sweep over every PHY address
        for (int p = 0; p < 32; p++)
            run_txn(1, mk(1'b0, 5'(p), 5'(31 - p), 16'(p * 16'h0841 + 16'h1357)), 16'h0, 1'b0);

        // R5 read sweep over divisors and addresses
        for (int d = 1; d <= 3; d++)
            for (int j = 0; j < 3; j++) begin
                int p;
                p = (j == 0) ? 0 : ((j == 1) ? 9 : 31);
                run_txn(d, mk(1'b1, 5'(p), 5'(p + d), 16'h0),
                        16'(16'hA5C3 ^ (p * 16'h0F0F) ^ (d * 16'h1111)), 1'b0);
            end
        run_txn(2, mk(1'b1, 5'd1, 5'd2, 16'h0), 16'hFFFF, 1'b0);
        run_txn(2, mk(1'b1, 5'd1, 5'd2, 16'h0), 16'h0000, 1'b0);

        // R9 busy writes ignored (write and read frames)
        run_txn(2, mk(1'b0, 5'd7, 5'd1, 16'h6C3A), 16'h0, 1'b1);
        run_txn(1, mk(1'b1, 5'd17, 5'd30, 16'h0), 16'h5AF0, 1'b1);

        // R7 zero write keeps, all ones clears
        wr(2'd2, 32'd2);
        wr(2'd0, mk(1'b0, 5'd2, 5'd2, 16'h0001));
        wait_event(400, seen);
        wr(2'd1, 32'd0);
        rd_now(2'd1, v);
        chk(v == 32'd1, "R7", "zero write keeps event", v, 32'd1);
        wr(2'd1, 32'hFFFF_FFFF);
        rd_now(2'd1, v);
        chk(v == 32'd0, "R7", "all ones clears event", v, 32'd0);

        // R10 soft reset during a transfer
        wr(2'd2, 32'd6);
        wr(2'd0, mk(1'b1, 5'd5, 5'd6, 16'h0));
        repeat (50) @(negedge clk);
        wr(2'd3, 32'd1);
        n = 0;
        rd_now(2'd3, v);
        while (v[0] && n < 100) begin
            n++;
            @(negedge clk);
            rd_now(2'd3, v);
        end
        chk(n == RSTC, "R10", "reset bit high cycles", 32'(n), 32'(RSTC));
        rd_now(2'd0, v);
        chk(v == 32'd0, "R10", "frame cleared", v, 32'd0);
        rd_now(2'd2, v);
        chk(v == 32'd0, "R10", "speed cleared", v, 32'd0);
        n = rise_total;
        repeat (300) @(negedge clk);
        rd_now(2'd1, v);
        chk(v == 32'd0, "R10", "no event after abort", v, 32'd0);
        chk(rise_total == n && !mdc && !mdio_oe, "R10", "bus idle after abort",
            32'(rise_total - n), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule